// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

The block keeps the time of day and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It runs from a reference clock. An internal divider counts `TICKS_PER_SEC` reference cycles for each second. Once per second an update cycle advances the counters and carries through the whole chain, including month lengths and leap years.

Software uses a byte-wide register bus. Reads are combinational from `addr_i`. Writes take effect on the rising clock edge while `wr_en_i` is high.

A status bit announces each update a fixed number of cycles before the counters change. It stays high until the update window has closed. Software that sees the bit low has a safe interval in which to read or write the time. A control register sets the coding of all time values (BCD or binary) and the hour format (12 or 24 hours). The same register has a freeze bit that stops updates while the clock is set. A second control register can hold the divider in reset. When the divider is released, the first update comes half a second later.

Top module: `rtc_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 1, month 1 and year 0. Control A reads 0x20, control B reads 0x02 (BCD, 24-hour, not frozen) and index 13 reads 0x80 (time valid).
- R2: The time values sit at indexes 0 (seconds), 2 (minutes), 4 (hours), 6 (day of week), 7 (date), 8 (month) and 9 (year). The control registers sit at 10 (A) and 11 (B). Index 12 and every unlisted index read 0, and writes to them change nothing.
- R3: Every `TICKS_PER_SEC` cycles an update increments seconds. Seconds 59 wraps to 0 and carries into minutes, minutes 59 carries into hours, and hour 23 carries into the next day. On that day change the day of week goes from 7 back to 1.
- R4: The date wraps after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and in February after day 29 when the year is a multiple of 4 and after day 28 otherwise. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R5: Bit 7 of control A (update in progress) is high for `UIP_LEAD + UIP_HOLD` consecutive cycles. The counters change at the clock edge that ends the `UIP_LEAD`-th of those cycles.
- R6: While bit 7 of control B (freeze) is 1, no update occurs and the update-in-progress bit reads 0.
- R7: A write to a time index is ignored when freeze is 0 and update in progress is 1. In every other case the write is accepted.
- R8: Bit 2 of control B selects binary coding when 1 and packed BCD (tens in bits 7:4, units in bits 3:0) when 0. The bit applies to both reads and writes of every time value.
- R9: Bit 1 of control B selects 24-hour hours when 1. When it is 0, hours read 1 to 12 with bit 7 set for PM: hour 0 reads as 12 AM and hour 12 reads as 12 PM. Hour writes in that mode are interpreted the same way.
- R10: Bits 6:4 of control A hold the divider. The codes 110 and 111 hold it in reset, which stops updates and keeps update in progress at 0. After any other code is written, update in progress first rises `TICKS_PER_SEC/2 - UIP_LEAD` cycles later, and the seconds change `TICKS_PER_SEC/2` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register index for read and write |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
A software write to a time register and the once-per-second counter update can both target the counters near the same clock edge. The update-in-progress window exists to keep them apart. The bench waits for the window to rise, then writes a seconds value inside it. After the window falls it requires the seconds to be exactly one more than before the window, so the update survived and the write was dropped. A write issued just after the window falls must be read back unchanged.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam logic [3:0] IDX_SEC  = 4'd0;
  localparam logic [3:0] IDX_MIN  = 4'd2;
  localparam logic [3:0] IDX_HR   = 4'd4;
  localparam logic [3:0] IDX_DOW  = 4'd6;
  localparam logic [3:0] IDX_DOM  = 4'd7;
  localparam logic [3:0] IDX_MON  = 4'd8;
  localparam logic [3:0] IDX_YR   = 4'd9;
  localparam logic [3:0] IDX_CTLA = 4'd10;
  localparam logic [3:0] IDX_CTLB = 4'd11;
  localparam logic [3:0] IDX_CTLD = 4'd13;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [3:0] mon;
    logic [6:0] yr;
  } cal_t;

  localparam cal_t CAL_RST = '{sec: 6'd0, min: 6'd0, hr: 5'd0, dow: 3'd1,
                               dom: 5'd1, mon: 4'd1, yr: 7'd0};

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                     return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  function automatic logic [7:0] encode_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] decode_val(input logic [7:0] c, input logic bin);
    logic [6:0] hi;
    hi = {3'b000, c[7:4]};
    return bin ? c[6:0] : hi * 7'd10 + {3'b000, c[3:0]};
  endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
  parameter int TPS  = 32768,
  parameter int LEAD = 8,
  parameter int HOLD = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic freeze_i,
  output logic tick_o,
  output logic uip_o
);
  localparam int CW = $clog2(TPS);
  localparam logic [CW-1:0] LAST       = CW'(TPS - 1);
  localparam logic [CW-1:0] HALF       = CW'(TPS / 2);
  localparam logic [CW-1:0] LEAD_START = CW'(TPS - LEAD);

  logic [CW-1:0] cnt_q;
  logic          tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= HALF;
    else if (hold_i)        cnt_q <= HALF;   // release lands half a second early
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HOLD > 0) begin : g_tail
      localparam logic [CW-1:0] HOLD_END = CW'(HOLD);
      assign tail = (cnt_q < HOLD_END);
    end else begin : g_no_tail
      assign tail = 1'b0;
    end
  endgenerate

  assign tick_o = !hold_i && !freeze_i && (cnt_q == LAST);
  assign uip_o  = !hold_i && !freeze_i && ((cnt_q >= LEAD_START) || tail);
endmodule

// File: rtl/rtc_counters.sv
`timescale 1ns/1ps
module rtc_counters
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ld_i,
  input  logic [3:0] ld_idx_i,
  input  logic [6:0] ld_val_i,
  output cal_t       cal_o
);
  cal_t q, nxt;

  always_comb begin
    nxt = q;
    if (q.sec != 6'd59) nxt.sec = q.sec + 6'd1;
    else begin
      nxt.sec = '0;
      if (q.min != 6'd59) nxt.min = q.min + 6'd1;
      else begin
        nxt.min = '0;
        if (q.hr != 5'd23) nxt.hr = q.hr + 5'd1;
        else begin
          nxt.hr  = '0;
          nxt.dow = (q.dow == 3'd7) ? 3'd1 : q.dow + 3'd1;
          if (q.dom != days_in_month(q.mon, q.yr)) nxt.dom = q.dom + 5'd1;
          else begin
            nxt.dom = 5'd1;
            if (q.mon != 4'd12) nxt.mon = q.mon + 4'd1;
            else begin
              nxt.mon = 4'd1;
              nxt.yr  = (q.yr == 7'd99) ? 7'd0 : q.yr + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CAL_RST;
    else if (ld_i) begin
      case (ld_idx_i)
        IDX_SEC: q.sec <= ld_val_i[5:0];
        IDX_MIN: q.min <= ld_val_i[5:0];
        IDX_HR:  q.hr  <= ld_val_i[4:0];
        IDX_DOW: q.dow <= ld_val_i[2:0];
        IDX_DOM: q.dom <= ld_val_i[4:0];
        IDX_MON: q.mon <= ld_val_i[3:0];
        IDX_YR:  q.yr  <= ld_val_i;
        default: ;
      endcase
    end else if (tick_i) q <= nxt;
  end

  assign cal_o = q;
endmodule

// File: rtl/rtc_calendar_clock.sv
`timescale 1ns/1ps
module rtc_calendar_clock
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8,
  parameter int UIP_HOLD      = 65
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [2:0] div_sel_q;
  logic       set_q, bin_q, h24_q;
  logic       div_hold, tick, uip, is_time, ld;
  logic [6:0] wr_plain, wr_mag, wr_hr, ld_val;
  logic [6:0] hr7, h12;
  logic [7:0] h12_enc, hr_enc;
  cal_t       cal;

  assign div_hold = (div_sel_q[2:1] == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_sel_q <= 3'b010;
      set_q     <= 1'b0;
      bin_q     <= 1'b0;
      h24_q     <= 1'b1;
    end else if (wr_en_i) begin
      if (addr_i == IDX_CTLA) div_sel_q <= wdata_i[6:4];
      if (addr_i == IDX_CTLB) begin
        set_q <= wdata_i[7];
        bin_q <= wdata_i[2];
        h24_q <= wdata_i[1];
      end
    end
  end

  rtc_divider #(.TPS(TICKS_PER_SEC), .LEAD(UIP_LEAD), .HOLD(UIP_HOLD)) u_div (
    .clk_i, .rst_ni, .hold_i(div_hold), .freeze_i(set_q), .tick_o(tick), .uip_o(uip)
  );

  always_comb begin
    case (addr_i)
      IDX_SEC, IDX_MIN, IDX_HR, IDX_DOW, IDX_DOM, IDX_MON, IDX_YR: is_time = 1'b1;
      default: is_time = 1'b0;
    endcase
  end

  // time writes are dropped inside the update window unless frozen
  assign ld = wr_en_i && is_time && (set_q || !uip);

  always_comb begin
    wr_plain = decode_val(wdata_i, bin_q);
    wr_mag   = decode_val({1'b0, wdata_i[6:0]}, bin_q);
    wr_hr    = ((wr_mag == 7'd12) ? 7'd0 : wr_mag) + (wdata_i[7] ? 7'd12 : 7'd0);
    ld_val   = (addr_i == IDX_HR && !h24_q) ? wr_hr : wr_plain;
  end

  rtc_counters u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ld_i(ld), .ld_idx_i(addr_i), .ld_val_i(ld_val), .cal_o(cal)
  );

  always_comb begin
    hr7     = 7'(cal.hr);
    h12     = (hr7 == 7'd0) ? 7'd12 : ((hr7 > 7'd12) ? hr7 - 7'd12 : hr7);
    h12_enc = encode_val(h12, bin_q);
    hr_enc  = h24_q ? encode_val(hr7, bin_q) : {hr7 >= 7'd12, h12_enc[6:0]};
    case (addr_i)
      IDX_SEC:  rdata_o = encode_val(7'(cal.sec), bin_q);
      IDX_MIN:  rdata_o = encode_val(7'(cal.min), bin_q);
      IDX_HR:   rdata_o = hr_enc;
      IDX_DOW:  rdata_o = encode_val(7'(cal.dow), bin_q);
      IDX_DOM:  rdata_o = encode_val(7'(cal.dom), bin_q);
      IDX_MON:  rdata_o = encode_val(7'(cal.mon), bin_q);
      IDX_YR:   rdata_o = encode_val(cal.yr, bin_q);
      IDX_CTLA: rdata_o = {uip, div_sel_q, 4'b0000};
      IDX_CTLB: rdata_o = {set_q, 4'b0000, bin_q, h24_q, 1'b0};
      IDX_CTLD: rdata_o = 8'h80;
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_clock_chk.sv
`timescale 1ns/1ps
module rtc_calendar_clock_chk
  import rtc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic uip_i,
  input logic div_hold_i,
  input logic set_i,
  input logic ld_i,
  input cal_t cal_i
);
  AST_SET_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_i) && !$past(ld_i)) |-> (cal_i == $past(cal_i))); // R6

  AST_UIP_OFF_IN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !uip_i); // R6

  AST_UPDATE_IN_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cal_i != $past(cal_i)) && !$past(ld_i)) |-> $past(uip_i)); // R5

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_hold_i) && !$past(ld_i)) |-> (cal_i == $past(cal_i))); // R10

  AST_DIV_HOLD_NO_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_hold_i |-> !uip_i); // R10

  AST_TIME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_i.sec < 6'd60) && (cal_i.min < 6'd60) && (cal_i.hr < 5'd24)); // R3
endmodule

bind rtc_calendar_clock rtc_calendar_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uip_i(uip), .div_hold_i(div_hold),
  .set_i(set_q), .ld_i(ld), .cal_i(cal)
);

// File: tb/rtc_calendar_clock_tb.sv
`timescale 1ns/1ps
module rtc_calendar_clock_tb;
  localparam int TPS = 40, LEAD = 4, HOLD = 6;
  localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd2, A_HR = 4'd4, A_DOW = 4'd6, A_DOM = 4'd7;
  localparam logic [3:0] A_MON = 4'd8, A_YR = 4'd9, A_CA = 4'd10, A_CB = 4'd11, A_CC = 4'd12, A_CD = 4'd13;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_clock #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD), .UIP_HOLD(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic wait_uip(input logic lvl);
    logic [7:0] v;
    for (int i = 0; i < 4*TPS; i++) begin
      rd(A_CA, v);
      if (v[7] == lvl) break;
    end
  endtask

  task automatic step();
    wait_uip(1'b1); wait_uip(1'b0);
  endtask

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // binary, 24-hour, not frozen; loads right after an update window
  task automatic load_cal(input int s, input int mi, input int h, input int dw,
                          input int dm, input int mo, input int y);
    step();
    wr(A_DOM, 8'd1); wr(A_MON, 8'(mo)); wr(A_YR, 8'(y)); wr(A_DOM, 8'(dm));
    wr(A_HR, 8'(h)); wr(A_MIN, 8'(mi)); wr(A_SEC, 8'(s)); wr(A_DOW, 8'(dw));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, s0;
    int k, cnt;
    logic seen;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(A_CA, v);  chk("R1 ctl A", v, 8'h20);
    rd(A_CB, v);  chk("R1 ctl B", v, 8'h02);
    rd(A_CD, v);  chk("R1 valid", v, 8'h80);
    rd(A_SEC, v); chk("R1 sec", v, 8'h00);
    rd(A_MIN, v); chk("R1 min", v, 8'h00);
    rd(A_HR, v);  chk("R1 hr", v, 8'h00);
    rd(A_DOW, v); chk("R1 dow", v, 8'h01);
    rd(A_DOM, v); chk("R1 dom", v, 8'h01);
    rd(A_MON, v); chk("R1 mon", v, 8'h01);
    rd(A_YR, v);  chk("R1 yr", v, 8'h00);

    // R2 unused indexes
    wr(4'd1, 8'h55); rd(4'd1, v);  chk("R2 idx1", v, 8'h00);
    wr(A_CC, 8'hff); rd(A_CC, v);  chk("R2 idx12", v, 8'h00);
    wr(4'd14, 8'h33); rd(4'd14, v); chk("R2 idx14", v, 8'h00);
    rd(A_CB, v); chk("R2 ctl B untouched", v, 8'h02);

    // R10 divider hold and half-second release
    wr(A_CA, 8'h60);
    wr(A_CB, 8'h86); wr(A_SEC, 8'd0); wr(A_CB, 8'h06);
    seen = 1'b0;
    for (int i = 0; i < 2*TPS; i++) begin rd(A_CA, v); if (v[7]) seen = 1'b1; end
    chk("R10 no uip in hold", {7'd0, seen}, 8'h00);
    rd(A_SEC, v); chk("R10 sec held", v, 8'd0);
    wr(A_CA, 8'h20);
    k = 0;
    for (int i = 0; i <= TPS; i++) begin
      rd(A_CA, v);
      if (v[7]) break;
      k++;
    end
    chk("R10 first uip delay", 8'(k), 8'(TPS/2 - LEAD));
    for (int j = 1; j <= LEAD; j++) begin
      rd(A_SEC, v);
      if (j == LEAD-1) chk("R5 sec before edge", v, 8'd0);
      if (j == LEAD)   chk("R10 R5 sec after edge", v, 8'd1);
    end

    // R5 window length
    wait_uip(1'b0); wait_uip(1'b1);
    cnt = 1;
    for (int i = 0; i < TPS; i++) begin
      rd(A_CA, v);
      if (!v[7]) break;
      cnt++;
    end
    chk("R5 uip length", 8'(cnt), 8'(LEAD + HOLD));

    // R7 write inside the window vs update
    wait_uip(1'b0);
    rd(A_SEC, s0);
    wait_uip(1'b1);
    wr(A_SEC, 8'd33);
    wait_uip(1'b0);
    rd(A_SEC, v); chk("R7 write in uip dropped", v, s0 + 8'd1);
    wr(A_SEC, 8'd45);
    rd(A_SEC, v); chk("R7 write outside uip", v, 8'd45);

    // R6 freeze
    wr(A_CB, 8'h86);
    rd(A_SEC, s0);
    seen = 1'b0;
    for (int i = 0; i < 3*TPS; i++) begin rd(A_CA, v); if (v[7]) seen = 1'b1; end
    chk("R6 uip low when frozen", {7'd0, seen}, 8'h00);
    rd(A_SEC, v); chk("R6 sec frozen", v, s0);

    // R8 coding sweep, frozen
    for (int s = 0; s < 60; s++) begin
      wr(A_CB, 8'h86); wr(A_SEC, 8'(s));
      wr(A_CB, 8'h82); rd(A_SEC, v);
      chk("R8 bcd read", v, {4'(s / 10), 4'(s % 10)});
      wr(A_SEC, {4'((59 - s) / 10), 4'((59 - s) % 10)});
      wr(A_CB, 8'h86); rd(A_SEC, v);
      chk("R8 bcd write", v, 8'(59 - s));
    end

    // R9 12-hour read sweep
    for (int h = 0; h < 24; h++) begin
      int e;
      wr(A_CB, 8'h86); wr(A_HR, 8'(h));
      wr(A_CB, 8'h84); rd(A_HR, v);
      e = (h % 12 == 0) ? 12 : h % 12;
      chk("R9 12h read", v, {h >= 12, 7'(e)});
    end
    wr(A_CB, 8'h80); wr(A_HR, 8'h92); wr(A_CB, 8'h82); rd(A_HR, v); chk("R9 noon write", v, 8'h12);
    wr(A_CB, 8'h80); wr(A_HR, 8'h12); wr(A_CB, 8'h82); rd(A_HR, v); chk("R9 midnight write", v, 8'h00);
    wr(A_CB, 8'h80); wr(A_HR, 8'h87); wr(A_CB, 8'h82); rd(A_HR, v); chk("R9 pm write", v, 8'h19);

    // R3 carry chain
    wr(A_CB, 8'h06);
    load_cal(59, 59, 12, 3, 10, 5, 1); step();
    rd(A_SEC, v); chk("R3 sec wrap", v, 8'd0);
    rd(A_MIN, v); chk("R3 min wrap", v, 8'd0);
    rd(A_HR, v);  chk("R3 hr carry", v, 8'd13);
    rd(A_DOM, v); chk("R3 dom unchanged", v, 8'd10);

    // R4 month ends over a full leap cycle
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        load_cal(59, 59, 23, 7, dim(m, y) - 1, m, y); step();
        rd(A_DOM, v); chk("R4 day before end", v, 8'(dim(m, y)));
        rd(A_MON, v); chk("R4 month kept", v, 8'(m));
        rd(A_DOW, v); chk("R3 dow wrap", v, 8'd1);
        load_cal(59, 59, 23, 7, dim(m, y), m, y); step();
        rd(A_DOM, v); chk("R4 date wrap", v, 8'd1);
        rd(A_MON, v); chk("R4 month step", v, 8'((m == 12) ? 1 : m + 1));
        rd(A_YR, v);  chk("R4 year", v, 8'((m == 12) ? y + 1 : y));
        rd(A_HR, v);  chk("R3 hr wrap", v, 8'd0);
      end
    end
    load_cal(59, 59, 23, 2, 31, 12, 99); step();
    rd(A_YR, v);  chk("R4 year 99 wrap", v, 8'd0);
    rd(A_MON, v); chk("R4 dec wrap", v, 8'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule